// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit orders two IEEE-754 operands, in single or double precision, and stores the two-bit outcome in one of four condition fields of a 64-bit floating-point status register. A 9-bit operation code picks the precision and whether the compare is quiet or signaling. A 2-bit selector picks which condition field receives the result. Every other bit of the status register keeps its value.

An operation is presented for one cycle with `op_valid` high. The unit takes one operation in every cycle and never stalls, so it has no ready output and the source needs no back-pressure handling. The status register and the three one-cycle flags change on the clock edge that samples the operation. Quad-precision codes are only flagged as needing other handling. Codes the unit does not recognise are flagged as unimplemented.

Top module: `fcc_compare_unit`

## Requirements
- R1: The condition code is 0 when the operands are equal, 1 when operand A is less than operand B, 2 when A is greater than B, and 3 when the pair is unordered.
- R2: Code 0x51 compares the low 32 bits of each operand as single precision, and the upper 32 bits have no effect. Code 0x52 compares all 64 bits as double precision.
- R3: An operand is NaN only when its exponent is all ones and its fraction is nonzero. An infinity (all-ones exponent, zero fraction) is ordered and compares by value.
- R4: Positive zero and negative zero compare as equal, in either order.
- R5: Ordering follows sign and magnitude. A negative value is less than a positive one, and of two negative values the one with the larger magnitude is the lesser.
- R6: The signaling codes 0x54 (single) and 0x55 (double) raise `ieee_exc` when either operand is NaN and also write code 3. The quiet codes 0x51 and 0x52 never raise `ieee_exc`.
- R7: The quad codes 0x53 and 0x56 raise `other_exc` and leave the status register unchanged.
- R8: Selector 0 writes status bits 11:10. Selector n (1..3) writes bits 2n+31:2n+30, which gives 33:32, 35:34 and 37:36.
- R9: A compare changes only the selected 2-bit field. All other status bits keep their values.
- R10: Any other code with `op_valid` high raises `unimpl` and leaves the status register unchanged.
- R11: Results appear on the clock edge that samples `op_valid`. Each flag is high for exactly that one cycle. A cycle without `op_valid` changes neither the status register nor the flags, and all flags read low afterwards.
- R12: A synchronous reset clears the status register and all flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| opcode | input | 9 | Compare operation code |
| fcc_sel | input | 2 | Condition field selector |
| src_a | input | 64 | Operand A (single precision in bits 31:0) |
| src_b | input | 64 | Operand B (single precision in bits 31:0) |
| status_q | output | 64 | Floating-point status register |
| ieee_exc | output | 1 | Signaling compare saw a NaN |
| other_exc | output | 1 | Quad compare requested |
| unimpl | output | 1 | Unrecognised operation code |

## Verification
The field write and the exception flag happen in the same cycle when a signaling compare meets a NaN. Code 3 must land in the selected field on the same edge that raises `ieee_exc`, and all other fields must stay as they were. The bench provokes this case with directed NaN pairs under each selector and with random NaN injection into signaling compares. In each such cycle it checks the whole status word against a model that tracks all four fields, and it checks the flag against the NaN rule.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int STATUS_W  = 64;
  localparam int MAG_W     = 63;
  localparam int OPC_W     = 9;
  localparam int SEL_W     = 2;
  localparam int CODE_W    = 2;

  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;

  localparam int FIELD0_LO    = 10;
  localparam int FIELD_EXT_LO = 30;

  localparam logic [OPC_W-1:0] OPC_QUIET_S = 9'h051;
  localparam logic [OPC_W-1:0] OPC_QUIET_D = 9'h052;
  localparam logic [OPC_W-1:0] OPC_QUIET_Q = 9'h053;
  localparam logic [OPC_W-1:0] OPC_SIG_S   = 9'h054;
  localparam logic [OPC_W-1:0] OPC_SIG_D   = 9'h055;
  localparam logic [OPC_W-1:0] OPC_SIG_Q   = 9'h056;

  typedef enum logic [CODE_W-1:0] {
    FCC_EQ  = 2'd0,
    FCC_LT  = 2'd1,
    FCC_GT  = 2'd2,
    FCC_UNO = 2'd3
  } fcc_code_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } fcc_opnd_t;

  function automatic int unsigned field_lo(input logic [SEL_W-1:0] sel);
    if (sel == '0) return FIELD0_LO;
    return 2 * int'(sel) + FIELD_EXT_LO;
  endfunction
endpackage

// File: rtl/fcc_operand_decode.sv
module fcc_operand_decode
  import fcc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = EXP_W + FRAC_W + 1
) (
  input  logic [WORD_W-1:0] word,
  output fcc_opnd_t         info
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = word[WORD_W-2 -: EXP_W];
  assign frac_f = word[FRAC_W-1:0];

  always_comb begin
    info      = '0;
    info.sign = word[WORD_W-1];
    info.nan  = (&exp_f) && (|frac_f);
    info.zero = ~|word[WORD_W-2:0];
    info.mag  = MAG_W'(word[WORD_W-2:0]);
  end
endmodule

// File: rtl/fcc_relate.sv
module fcc_relate
  import fcc_pkg::*;
(
  input  fcc_opnd_t opa,
  input  fcc_opnd_t opb,
  output fcc_code_e code,
  output logic      any_nan
);
  logic mag_lt, mag_gt;

  assign mag_lt  = opa.mag < opb.mag;
  assign mag_gt  = opa.mag > opb.mag;
  assign any_nan = opa.nan | opb.nan;

  always_comb begin
    if (any_nan)
      code = FCC_UNO;
    else if (opa.zero && opb.zero)
      code = FCC_EQ;
    else if (opa.sign != opb.sign)
      code = opa.sign ? FCC_LT : FCC_GT;
    else if (!mag_lt && !mag_gt)
      code = FCC_EQ;
    else if (opa.sign)
      code = mag_lt ? FCC_GT : FCC_LT;
    else
      code = mag_lt ? FCC_LT : FCC_GT;
  end
endmodule

// File: rtl/fcc_status_reg.sv
module fcc_status_reg
  import fcc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    sel,
  input  fcc_code_e           code,
  output logic [STATUS_W-1:0] status_q
);
  localparam int NUM_FIELDS = 1 << SEL_W;

  logic [NUM_FIELDS-1:0] field_hit;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam int LO = field_lo(SEL_W'(f));
    assign field_hit[f] = wr_en && (sel == SEL_W'(f));
    always_ff @(posedge clk) begin
      if (rst)
        status_q[LO +: CODE_W] <= '0;
      else if (field_hit[f])
        status_q[LO +: CODE_W] <= code;
    end
  end

  for (genvar b = 0; b < STATUS_W; b++) begin : g_fixed
    localparam bit IN_FIELD = (b >= field_lo(2'd0) && b < field_lo(2'd0) + CODE_W)
                           || (b >= field_lo(2'd1) && b < field_lo(2'd3) + CODE_W);
    if (!IN_FIELD) begin : g_keep
      always_ff @(posedge clk) begin
        if (rst) status_q[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fcc_compare_unit.sv
module fcc_compare_unit
  import fcc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [OPC_W-1:0]    opcode,
  input  logic [SEL_W-1:0]    fcc_sel,
  input  logic [63:0]         src_a,
  input  logic [63:0]         src_b,
  output logic [STATUS_W-1:0] status_q,
  output logic                ieee_exc,
  output logic                other_exc,
  output logic                unimpl
);
  fcc_opnd_t sp_info [2];
  fcc_opnd_t dp_info [2];
  fcc_opnd_t sel_info [2];
  logic [63:0] src [2];

  assign src[0] = src_a;
  assign src[1] = src_b;

  logic is_dbl, is_sig, is_cmp, is_quad;

  always_comb begin
    is_dbl  = 1'b0;
    is_sig  = 1'b0;
    is_cmp  = 1'b0;
    is_quad = 1'b0;
    unique case (opcode)
      OPC_QUIET_S: is_cmp = 1'b1;
      OPC_QUIET_D: begin is_cmp = 1'b1; is_dbl = 1'b1; end
      OPC_SIG_S:   begin is_cmp = 1'b1; is_sig = 1'b1; end
      OPC_SIG_D:   begin is_cmp = 1'b1; is_sig = 1'b1; is_dbl = 1'b1; end
      OPC_QUIET_Q, OPC_SIG_Q: is_quad = 1'b1;
      default: ;
    endcase
  end

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    fcc_operand_decode #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
      .word (src[k][31:0]),
      .info (sp_info[k])
    );
    fcc_operand_decode #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
      .word (src[k]),
      .info (dp_info[k])
    );
    assign sel_info[k] = is_dbl ? dp_info[k] : sp_info[k];
  end

  fcc_code_e cmp_code;
  logic      cmp_nan;

  fcc_relate u_relate (
    .opa     (sel_info[0]),
    .opb     (sel_info[1]),
    .code    (cmp_code),
    .any_nan (cmp_nan)
  );

  fcc_status_reg u_status (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (op_valid && is_cmp),
    .sel      (fcc_sel),
    .code     (cmp_code),
    .status_q (status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ieee_exc  <= 1'b0;
      other_exc <= 1'b0;
      unimpl    <= 1'b0;
    end else begin
      ieee_exc  <= op_valid && is_cmp && is_sig && cmp_nan;
      other_exc <= op_valid && is_quad;
      unimpl    <= op_valid && !is_cmp && !is_quad;
    end
  end
endmodule

// File: rtl/fcc_compare_unit_chk.sv
module fcc_compare_unit_chk
  import fcc_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                op_valid,
  input logic [OPC_W-1:0]    opcode,
  input logic [SEL_W-1:0]    fcc_sel,
  input logic [63:0]         src_a,
  input logic [63:0]         src_b,
  input logic [STATUS_W-1:0] status_q,
  input logic                ieee_exc,
  input logic                other_exc,
  input logic                unimpl
);
  function automatic logic [STATUS_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
    logic [STATUS_W-1:0] m;
    m = '0;
    m[field_lo(s) +: CODE_W] = 2'b11;
    return m;
  endfunction

  logic is_cmp_op;
  assign is_cmp_op = (opcode == OPC_QUIET_S) || (opcode == OPC_QUIET_D) ||
                     (opcode == OPC_SIG_S)   || (opcode == OPC_SIG_D);

  // R9: only the selected field may change after a compare
  a_r9_other_bits_kept: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_cmp_op) |=>
      ((status_q & ~sel_mask($past(fcc_sel))) == ($past(status_q) & ~sel_mask($past(fcc_sel)))));

  // R7 / R10: quad and unknown codes leave the status register alone
  a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !is_cmp_op) |=> (status_q == $past(status_q)));

  // R11: idle cycles change nothing and leave the flags low
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(status_q) && !ieee_exc && !other_exc && !unimpl));

  // R6: a raised IEEE flag comes with code 3 in the selected field
  a_r6_exc_unordered: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_cmp_op) |=>
      (!ieee_exc || ((status_q & sel_mask($past(fcc_sel))) == sel_mask($past(fcc_sel)))));

  // R6: quiet compares never raise the IEEE flag
  a_r6_quiet_no_exc: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (opcode == OPC_QUIET_S || opcode == OPC_QUIET_D)) |=> !ieee_exc);

  // R11: at most one flag at a time
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ieee_exc, other_exc, unimpl}));
endmodule

bind fcc_compare_unit fcc_compare_unit_chk chk_i (.*);

// File: tb/fcc_compare_unit_tb_top.sv
module fcc_compare_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [8:0]  opcode = '0;
  logic [1:0]  fcc_sel = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [63:0] status_q;
  logic        ieee_exc, other_exc, unimpl;

  int n_checks = 0;
  int n_bad = 0;
  logic [63:0] model = '0;

  always #10 clk = ~clk;

  fcc_compare_unit dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Total order key: NaN excluded, -0 folded to +0
  function automatic logic [64:0] okey(input logic [63:0] w, input bit dbl);
    logic [63:0] v;
    v = dbl ? w : {32'h0, w[31:0]};
    if (dbl) begin
      if (v[62:0] == 0) v = 64'h0;
      return v[63] ? {1'b0, ~v} : {1'b1, v};
    end
    if (v[30:0] == 0) v = 64'h0;
    return v[31] ? {1'b0, 32'h0, ~v[31:0]} : {1'b1, 32'h0, v[31:0]};
  endfunction

  function automatic bit isnan(input logic [63:0] w, input bit dbl);
    if (dbl) return (w[62:52] == 11'h7ff) && (w[51:0] != 0);
    return (w[30:23] == 8'hff) && (w[22:0] != 0);
  endfunction

  function automatic logic [1:0] ref_code(input logic [63:0] a, input logic [63:0] b, input bit dbl);
    if (isnan(a, dbl) || isnan(b, dbl)) return 2'd3;
    if (okey(a, dbl) == okey(b, dbl)) return 2'd0;
    return (okey(a, dbl) < okey(b, dbl)) ? 2'd1 : 2'd2;
  endfunction

  function automatic int fpos(input logic [1:0] s);
    return (s == 0) ? 10 : 30 + 2 * int'(s);
  endfunction

  task automatic run_op(input string req, input logic [8:0] opc, input logic [1:0] s,
                        input logic [63:0] a, input logic [63:0] b);
    bit dbl, cmp, sig, quad, nan;
    logic [2:0] eflags;
    dbl  = (opc == 9'h052) || (opc == 9'h055);
    sig  = (opc == 9'h054) || (opc == 9'h055);
    cmp  = (opc == 9'h051) || dbl || sig;
    quad = (opc == 9'h053) || (opc == 9'h056);
    nan  = isnan(a, dbl) || isnan(b, dbl);
    @(negedge clk);
    op_valid = 1'b1; opcode = opc; fcc_sel = s; src_a = a; src_b = b;
    if (cmp) model[fpos(s) +: 2] = ref_code(a, b, dbl);
    eflags = {cmp && sig && nan, quad, !cmp && !quad};
    @(posedge clk); #2;
    check(req, status_q, model);
    check({req, " flags"}, {61'h0, ieee_exc, other_exc, unimpl}, {61'h0, eflags});
    op_valid = 1'b0;
  endtask

  function automatic logic [63:0] rnd_val(input bit dbl);
    logic [63:0] w;
    int pick;
    w = {$urandom, $urandom};
    pick = $urandom_range(0, 9);
    if (dbl) begin
      case (pick)
        0: w[62:52] = 11'h7ff;
        1: w[62:0] = 63'h0;
        2: w = {w[63], 11'h7ff, 52'h0};
        3: w[62:56] = 7'h40;
        default: ;
      endcase
    end else begin
      case (pick)
        0: w[30:23] = 8'hff;
        1: w[30:0] = 31'h0;
        2: w[30:0] = {8'hff, 23'h0};
        3: w[30:26] = 5'h10;
        default: ;
      endcase
    end
    return w;
  endfunction

  initial begin
    #4_000_000;
    n_checks++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    check("R12 reset status", status_q, 64'h0);
    check("R12 reset flags", {61'h0, ieee_exc, other_exc, unimpl}, 64'h0);
    @(negedge clk); rst = 1'b0;

    // R1/R2 single: 1.0 vs 2.0 -> LT, upper bits junk
    run_op("R1 R2 single lt", 9'h051, 2'd0, 64'hdead_beef_3f80_0000, 64'h1234_5678_4000_0000);
    run_op("R1 single gt", 9'h051, 2'd1, 64'h4000_0000, 64'h3f80_0000);
    run_op("R1 single eq", 9'h051, 2'd2, 64'h4040_0000, 64'hffff_ffff_4040_0000);
    run_op("R2 double lt", 9'h052, 2'd3, 64'h3ff0_0000_0000_0000, 64'h4000_0000_0000_0000);
    // R4 zeros
    run_op("R4 zero eq", 9'h052, 2'd0, 64'h8000_0000_0000_0000, 64'h0);
    run_op("R4 zero eq sp", 9'h054, 2'd1, 64'h0, 64'h8000_0000);
    // R5 negatives: -2 < -1
    run_op("R5 neg order", 9'h052, 2'd2, 64'hc000_0000_0000_0000, 64'hbff0_0000_0000_0000);
    run_op("R5 sign order", 9'h051, 2'd3, 64'h3f80_0000, 64'hbf80_0000);
    // R3 infinity ordered, NaN unordered
    run_op("R3 inf gt", 9'h055, 2'd0, 64'h7ff0_0000_0000_0000, 64'h4000_0000_0000_0000);
    run_op("R3 nan quiet", 9'h051, 2'd1, 64'h7fc0_0000, 64'h3f80_0000);
    // R6 signaling NaN: code 3 and flag together, each selector (R8)
    for (int s = 0; s < 4; s++) begin
      run_op("R6 R8 sig nan", 9'h055, 2'(s), 64'h3ff0_0000_0000_0000, 64'h7ff0_0000_0000_0001);
      run_op("R8 R9 field write", 9'h052, 2'(s), 64'h0, 64'h3ff0_0000_0000_0000);
    end
    // R7 quad, R10 unknown
    run_op("R7 quad", 9'h053, 2'd0, 64'h1, 64'h2);
    run_op("R7 quad sig", 9'h056, 2'd2, 64'h7ff8_0000_0000_0000, 64'h2);
    run_op("R10 unknown", 9'h057, 2'd1, 64'h0, 64'h3ff0_0000_0000_0000);
    run_op("R10 unknown", 9'h000, 2'd3, 64'h0, 64'h0);
    // R11 idle cycle
    @(negedge clk); #1;
    @(posedge clk); #2;
    check("R11 idle status", status_q, model);
    check("R11 idle flags", {61'h0, ieee_exc, other_exc, unimpl}, 64'h0);

    for (int i = 0; i < 400; i++) begin
      logic [8:0] opc;
      int p;
      bit dbl;
      p = $urandom_range(0, 9);
      case (p)
        0, 1: opc = 9'h051;
        2, 3: opc = 9'h052;
        4, 5: opc = 9'h054;
        6, 7: opc = 9'h055;
        8:    opc = ($urandom_range(0, 1) != 0) ? 9'h053 : 9'h056;
        default: opc = 9'($urandom);
      endcase
      dbl = (opc == 9'h052) || (opc == 9'h055);
      if ($urandom_range(0, 3) == 0) begin
        logic [63:0] v;
        v = rnd_val(dbl);
        run_op("R1 R5 random same", opc, 2'($urandom), v, v);
      end else
        run_op("R1 R6 R9 random", opc, 2'($urandom), rnd_val(dbl), rnd_val(dbl));
    end

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    model = '0;
    check("R12 reset again", status_q, 64'h0);

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule